// File: doc/BRIEF.md
# Reply timeout encoder

This block turns a requested reply timeout, given in microseconds, into the two fields that a link receiver's timeout counter consumes: a 2-bit unit code that picks a tick size of 8, 16, 32 or 64 us, and a 7-bit tick count. The unit is chosen by the range that the request falls in, and the count is rounded up so that the programmed timeout is never shorter than the request. Both fields are held in one control register that loads on a write strobe.

Each write also reports the timeout that the register held just before the write. This lets a caller restore the earlier setting later. The same strobe also latches a software polling period, which is the request scaled by a fixed parameter. A request of zero restores the default setting.

Top module: `reply_timeout_encoder`

## Requirements
- R1: While reset is high and after it is released, the register holds unit code 0 and count 69, and the previous-timeout and polling outputs read 0.
- R2: A request of 0 us programs unit code 0 and count 69.
- R3: The unit code maps as 0 = 8 us, 1 = 16 us, 2 = 32 us, 3 = 64 us. A nonzero request of at most 1016 us takes code 0. A request of at most 2032 us takes code 1. A request of at most 4064 us takes code 2. Any larger request takes code 3.
- R4: The count is the request divided by the selected unit, plus one when the division leaves a remainder.
- R5: A count that would exceed 127 is programmed as 127.
- R6: On each write, the previous-timeout output takes the count held before the write, multiplied by the unit of the code held before the write.
- R7: The count and the code update together at the rising edge that samples the write strobe. The previous-timeout and polling outputs update at that same edge.
- R8: When the write strobe is low, every output keeps its value, whatever the request input does.
- R9: On each write, the polling output takes the request multiplied by POLL_MULT (default 10).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_us | input | REQ_W (16) | Requested timeout in microseconds |
| wr_en | input | 1 | Loads the register from req_us |
| len_q | output | LEN_W (7) | Programmed tick count |
| mult_q | output | 2 | Programmed unit code |
| prev_us | output | LEN_W+UNIT_LOG2+3 (13) | Timeout held before the last write, in microseconds |
| poll_us | output | REQ_W+POLL_GROW (20) | Software polling period from the last write |

## Verification
Every result of a write appears at the rising edge that samples the strobe. This covers the new count, the new code, the previous timeout and the polling period. After that edge they hold until the next write. The bench raises the strobe on a falling edge and drops it on the next falling edge. It reads all four outputs on that same falling edge, which is half a cycle after the loading edge. For the hold checks, the bench changes the request with the strobe low and reads the outputs several falling edges later. The previous-timeout check is made as a chain of writes, so each expected value comes from the fields programmed by the write before it.

// File: rtl/rto_pkg.sv
package rto_pkg;
  localparam int CODE_W    = 2;
  localparam int NUM_CODES = 1 << CODE_W;

  typedef enum logic [CODE_W-1:0] {
    UNIT_X1 = 2'd0,
    UNIT_X2 = 2'd1,
    UNIT_X4 = 2'd2,
    UNIT_X8 = 2'd3
  } unit_code_t;
endpackage

// File: rtl/rto_range_sel.sv
module rto_range_sel
  import rto_pkg::*;
#(
  parameter int REQ_W     = 16,
  parameter int LEN_W     = 7,
  parameter int UNIT_LOG2 = 3
) (
  input  logic [REQ_W-1:0] req,
  output unit_code_t       code
);
  localparam int MAX_LEN = (1 << LEN_W) - 1;
  localparam int STEP    = MAX_LEN << UNIT_LOG2;
  localparam int CMP_W   = REQ_W + NUM_CODES;

  logic [NUM_CODES-2:0] above;

  // One comparator per range boundary; each boundary doubles the previous.
  generate
    for (genvar k = 0; k < NUM_CODES - 1; k++) begin : g_cmp
      localparam logic [CMP_W-1:0] LIM = CMP_W'(STEP) << k;
      assign above[k] = {{NUM_CODES{1'b0}}, req} > LIM;
    end
  endgenerate

  always_comb begin
    code = UNIT_X1;
    for (int k = 0; k < NUM_CODES - 1; k++) begin
      if (above[k]) code = unit_code_t'(CODE_W'(k + 1));
    end
  end
endmodule

// File: rtl/rto_len_calc.sv
module rto_len_calc
  import rto_pkg::*;
#(
  parameter int REQ_W     = 16,
  parameter int LEN_W     = 7,
  parameter int UNIT_LOG2 = 3,
  parameter int DEF_LEN   = 69
) (
  input  logic [REQ_W-1:0] req,
  input  unit_code_t       code,
  output logic [LEN_W-1:0] len
);
  localparam int MAX_LEN = (1 << LEN_W) - 1;

  logic [REQ_W:0] quo [NUM_CODES];

  // Ceiling quotient for every unit size, chosen later by the code.
  generate
    for (genvar k = 0; k < NUM_CODES; k++) begin : g_div
      localparam int SH = UNIT_LOG2 + k;
      assign quo[k] = ({1'b0, req} + (REQ_W+1)'((1 << SH) - 1)) >> SH;
    end
  endgenerate

  logic [REQ_W:0] raw;
  always_comb begin
    raw = quo[code];
    if (req == '0)
      len = LEN_W'(DEF_LEN);
    else if (raw > (REQ_W+1)'(MAX_LEN))
      len = LEN_W'(MAX_LEN);
    else
      len = raw[LEN_W-1:0];
  end

  // R4: any nonzero request gives a nonzero count
  always_comb begin
    assert_len_nonzero_R4 : assert (req == '0 || len != '0);
  end
endmodule

// File: rtl/rto_prev_decode.sv
module rto_prev_decode
  import rto_pkg::*;
#(
  parameter int LEN_W     = 7,
  parameter int UNIT_LOG2 = 3,
  parameter int DEF_LEN   = 69,
  parameter int PREV_W    = LEN_W + UNIT_LOG2 + NUM_CODES - 1
) (
  input  logic [LEN_W-1:0]  len,
  input  unit_code_t        code,
  output logic [PREV_W-1:0] us
);
  always_comb begin
    unique case (code)
      UNIT_X1: us = PREV_W'(len) << UNIT_LOG2;
      UNIT_X2: us = PREV_W'(len) << (UNIT_LOG2 + 1);
      UNIT_X4: us = PREV_W'(len) << (UNIT_LOG2 + 2);
      UNIT_X8: us = PREV_W'(len) << (UNIT_LOG2 + 3);
      default: us = PREV_W'(DEF_LEN) << UNIT_LOG2;
    endcase
  end
endmodule

// File: rtl/reply_timeout_encoder.sv
module reply_timeout_encoder
  import rto_pkg::*;
#(
  parameter int REQ_W     = 16,
  parameter int LEN_W     = 7,
  parameter int UNIT_LOG2 = 3,
  parameter int DEF_LEN   = 69,
  parameter int POLL_MULT = 10,
  parameter int POLL_GROW = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [REQ_W-1:0]             req_us,
  input  logic                         wr_en,
  output logic [LEN_W-1:0]             len_q,
  output logic [1:0]                   mult_q,
  output logic [LEN_W+UNIT_LOG2+2:0]   prev_us,
  output logic [REQ_W+POLL_GROW-1:0]   poll_us
);
  localparam int PREV_W  = LEN_W + UNIT_LOG2 + 3;
  localparam int POLL_W  = REQ_W + POLL_GROW;
  localparam int MAX_LEN = (1 << LEN_W) - 1;
  localparam int STEP    = MAX_LEN << UNIT_LOG2;

  unit_code_t          code_d;
  logic [LEN_W-1:0]    len_d;
  logic [PREV_W-1:0]   prev_d;
  logic [POLL_W-1:0]   poll_d;

  rto_range_sel #(.REQ_W(REQ_W), .LEN_W(LEN_W), .UNIT_LOG2(UNIT_LOG2)) u_range (
    .req  (req_us),
    .code (code_d)
  );

  rto_len_calc #(.REQ_W(REQ_W), .LEN_W(LEN_W), .UNIT_LOG2(UNIT_LOG2),
                 .DEF_LEN(DEF_LEN)) u_len (
    .req  (req_us),
    .code (code_d),
    .len  (len_d)
  );

  // Decodes the currently held fields, so the value is taken before the load.
  rto_prev_decode #(.LEN_W(LEN_W), .UNIT_LOG2(UNIT_LOG2), .DEF_LEN(DEF_LEN),
                    .PREV_W(PREV_W)) u_prev (
    .len  (len_q),
    .code (unit_code_t'(mult_q)),
    .us   (prev_d)
  );

  assign poll_d = POLL_W'(req_us) * POLL_W'(POLL_MULT);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= LEN_W'(DEF_LEN);
      mult_q  <= UNIT_X1;
      prev_us <= '0;
      poll_us <= '0;
    end else if (wr_en) begin
      len_q   <= len_d;
      mult_q  <= code_d;
      prev_us <= prev_d;
      poll_us <= poll_d;
    end
  end

  // R2: zero request restores the default fields
  assert_zero_default_R2 : assert property (@(posedge clk) disable iff (rst)
    (wr_en && req_us == '0) |=> (mult_q == 2'd0 && len_q == LEN_W'(DEF_LEN)));

  // R3: a request in the first range keeps the finest unit
  assert_first_range_R3 : assert property (@(posedge clk) disable iff (rst)
    (wr_en && req_us != '0 && 32'(req_us) <= STEP) |=> (mult_q == 2'd0));

  // R6: previous timeout reflects the fields held before the write
  assert_prev_value_R6 : assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (32'(prev_us) == (32'($past(len_q)) << (UNIT_LOG2 + 32'($past(mult_q))))));

  // R8: no strobe, no change
  assert_hold_R8 : assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(len_q) && $stable(mult_q) && $stable(prev_us) && $stable(poll_us)));

  // R9: polling period follows the request
  assert_poll_R9 : assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (32'(poll_us) == 32'($past(req_us)) * POLL_MULT));
endmodule

// File: tb/test_reply_timeout_encoder.sv
`timescale 1ns/1ps
module test_reply_timeout_encoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req_us = '0;
  logic        wr_en = 1'b0;
  logic [6:0]  len_q;
  logic [1:0]  mult_q;
  logic [12:0] prev_us;
  logic [19:0] poll_us;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reply_timeout_encoder i_reply_timeout_encoder (
    .clk(clk), .rst(rst), .req_us(req_us), .wr_en(wr_en),
    .len_q(len_q), .mult_q(mult_q), .prev_us(prev_us), .poll_us(poll_us)
  );

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Model built from the requirement text only.
  function automatic int exp_code(input int r);
    if (r == 0)         return 0;
    else if (r <= 1016) return 0;
    else if (r <= 2032) return 1;
    else if (r <= 4064) return 2;
    else                return 3;
  endfunction

  function automatic int exp_len(input int r);
    int unit, l;
    if (r == 0) return 69;
    unit = 8 << exp_code(r);
    l = r / unit + ((r % unit) != 0 ? 1 : 0);
    return (l > 127) ? 127 : l;
  endfunction

  task automatic do_write(input int r);
    @(negedge clk);
    req_us = 16'(r);
    wr_en  = 1'b1;
    @(negedge clk);
    wr_en  = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "len after reset", len_q, 69);
    check("R1", "code after reset", mult_q, 0);
    check("R1", "prev after reset", prev_us, 0);
    check("R1", "poll after reset", poll_us, 0);
  endtask

  task automatic t_encode(input string tag, input int r);
    do_write(r);
    check(tag, $sformatf("code for %0d", r), mult_q, exp_code(r));
    check(tag, $sformatf("len for %0d", r), len_q, exp_len(r));
    check("R9", $sformatf("poll for %0d", r), poll_us, r * 10);
  endtask

  task automatic t_prev(input int r, input int exp_prev);
    do_write(r);
    check("R6", $sformatf("prev at write %0d", r), prev_us, exp_prev);
    check("R7", $sformatf("fields at write %0d", r), {mult_q, len_q},
          (exp_code(r) << 7) | exp_len(r));
  endtask

  task automatic t_hold;
    logic [6:0] l0; logic [1:0] m0; logic [12:0] p0; logic [19:0] q0;
    do_write(3000);
    l0 = len_q; m0 = mult_q; p0 = prev_us; q0 = poll_us;
    @(negedge clk); req_us = 16'd9;
    @(negedge clk); req_us = 16'd0;
    @(negedge clk); req_us = 16'd60000;
    repeat (3) @(negedge clk);
    check("R8", "len held", len_q, l0);
    check("R8", "code held", mult_q, m0);
    check("R8", "prev held", prev_us, p0);
    check("R8", "poll held", poll_us, q0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    // R2 zero request
    t_encode("R2", 500);
    t_encode("R2", 0);
    // R3 range edges
    t_encode("R3", 1);
    t_encode("R3", 1016);
    t_encode("R3", 1017);
    t_encode("R3", 2032);
    t_encode("R3", 2033);
    t_encode("R3", 4064);
    t_encode("R3", 4065);
    // R4 rounding
    t_encode("R4", 8);
    t_encode("R4", 9);
    t_encode("R4", 100);
    t_encode("R4", 3000);
    // R5 saturation
    t_encode("R5", 8200);
    t_encode("R5", 10000);
    t_encode("R5", 65535);
    // R6 / R7 chain from reset state
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    t_prev(1017, 552);
    t_prev(4065, 1024);
    t_prev(9, 4096);
    t_prev(0, 16);
    t_prev(2033, 552);
    t_prev(700, 2048);
    t_hold;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule